// File: doc/BRIEF.md
# Processor Status Flags and Interrupt Mask Unit

This unit holds the 8-bit status byte of a small accumulator processor. Each cycle it takes the result of the arithmetic unit together with the class of the current operation and per-flag update enables. From these it keeps the half-carry, negative, zero and carry flags. Alongside the flags it holds an interrupt mask bit, which instruction strobes set or clear. A return-from-interrupt strobe reloads the whole byte from a value pulled off the stack.

The unit also gates the external interrupt request. A request that arrives while the mask is clear produces a one-cycle take pulse for the instruction sequencer, and the mask is set in the same cycle. The sequencer then saves the registers and fetches the vector. A request that arrives while the mask is set, or while an instruction in that cycle is setting it, is held as pending. It is taken in the cycle after the mask returns to zero. Instruction decode, stacking and the vector fetch belong to the sequencer.

Top module: `ccr_unit`

## Requirements
- R1: Status byte bits 7, 6 and 5 always read 1, including after a return-from-interrupt reload whose byte has them at 0.
- R2: Bit 4 (half-carry) is loaded from `alu_half` only when `op_class` is 1 (add) or 2 (add with carry). Classes 0 and 3 leave it unchanged.
- R3: When `upd_nz` is high, bit 2 (negative) takes bit 7 of `alu_res` and bit 1 (zero) is 1 exactly when `alu_res` is all zeros. Otherwise both are held.
- R4: When `upd_c` is high, bit 0 (carry) takes `alu_carry`. Otherwise it is held.
- R5: A cycle with `rst` high sets bit 3 (mask) and clears `take_irq` and `irq_pending`. It leaves bits 4, 2, 1 and 0 unchanged.
- R6: `sei_stb` sets the mask. Any of `cli_stb`, `stop_stb` or `wait_stb` clears it. When both kinds of strobe arrive in one cycle, the set wins.
- R7: `rti_stb` loads bits 4..0 from `rti_byte` on the next edge. This overrides the flag updates and the mask strobes of that cycle.
- R8: A cycle with the mask at 0, a request (`irq_req` or pending), and neither `sei_stb` nor `rti_stb` high gives `take_irq` high for exactly one cycle on the next edge. In that cycle the mask reads 1 and `irq_pending` reads 0.
- R9: A request that is not taken sets `irq_pending` on the next edge. The pending state holds until it is taken or reset.
- R10: A pending request is taken one cycle after the mask has been cleared by `cli_stb`, `stop_stb`, `wait_stb` or a reload with bit 3 at 0. Any number of requests merged while pending produce exactly one take.
- R11: `take_irq` is never asserted on the edge after a cycle in which `sei_stb` or `rti_stb` was high. The request stays pending instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | 0 other, 1 add, 2 add with carry, 3 other |
| alu_res | input | 8 | Arithmetic result |
| alu_half | input | 1 | Carry from bit 3 into bit 4 |
| alu_carry | input | 1 | Carry or borrow out |
| upd_nz | input | 1 | Update negative and zero flags |
| upd_c | input | 1 | Update carry flag |
| cli_stb | input | 1 | Clear-mask instruction |
| sei_stb | input | 1 | Set-mask instruction |
| stop_stb | input | 1 | Stop instruction (clears mask) |
| wait_stb | input | 1 | Wait instruction (clears mask) |
| rti_stb | input | 1 | Return-from-interrupt reload |
| rti_byte | input | 8 | Byte restored from the stack |
| irq_req | input | 1 | Interrupt request event |
| ccr_q | output | 8 | Status byte |
| take_irq | output | 1 | One-cycle interrupt entry pulse |
| irq_pending | output | 1 | A held request is waiting |

## Verification
The bench targets a request that arrives in the same cycle as a set-mask or reload strobe. A design that did not block it would pulse `take_irq` during a mask change and lose the request. It clears the mask by each of the three instructions and by a reload. A design that clears pending without taking it, or that takes it twice, shows a missing or doubled pulse. Reloads with the top bits at zero and add-versus-other operations show an unforced top bit or a half-carry that updates on the wrong class. A reset with known flags catches a design that wipes H, N, Z or C.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int CCR_W   = 8;
    localparam int BIT_H   = 4;
    localparam int BIT_I   = 3;
    localparam int BIT_N   = 2;
    localparam int BIT_Z   = 1;
    localparam int BIT_C   = 0;

    typedef enum logic [1:0] {
        OPC_OTHER = 2'd0,
        OPC_ADD   = 2'd1,
        OPC_ADC   = 2'd2,
        OPC_SPARE = 2'd3
    } op_class_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic c;
    } arith_flags_t;

    function automatic logic is_add_class(op_class_e oc);
        return (oc == OPC_ADD) || (oc == OPC_ADC);
    endfunction

    function automatic logic [CCR_W-1:0] pack_status(arith_flags_t f, logic mask);
        logic [CCR_W-1:0] b;
        b        = '1;
        b[BIT_H] = f.h;
        b[BIT_I] = mask;
        b[BIT_N] = f.n;
        b[BIT_Z] = f.z;
        b[BIT_C] = f.c;
        return b;
    endfunction

    function automatic arith_flags_t unpack_flags(logic [CCR_W-1:0] b);
        arith_flags_t f;
        f.h = b[BIT_H];
        f.n = b[BIT_N];
        f.z = b[BIT_Z];
        f.c = b[BIT_C];
        return f;
    endfunction

endpackage

// File: rtl/ccr_flag_logic.sv
module ccr_flag_logic
    import ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  arith_flags_t      cur,
    input  op_class_e         oc,
    input  logic [DATA_W-1:0] res,
    input  logic              half,
    input  logic              carry,
    input  logic              upd_nz,
    input  logic              upd_c,
    input  logic              reload,
    input  arith_flags_t      reload_val,
    output arith_flags_t      nxt
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        nxt = cur;
        if (reload) begin
            nxt = reload_val;
        end else begin
            if (is_add_class(oc)) nxt.h = half;
            if (upd_nz) begin
                nxt.n = res[MSB];
                nxt.z = (res == '0);
            end
            if (upd_c) nxt.c = carry;
        end
    end
endmodule

// File: rtl/ccr_mask_ctrl.sv
module ccr_mask_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_mask,
    input  logic clr_mask,
    input  logic reload,
    input  logic reload_mask,
    input  logic irq_req,
    output logic mask_q,
    output logic pend_q,
    output logic take_q
);
    logic req_any;
    logic fire;
    logic mask_nxt;

    always_comb begin
        req_any  = pend_q | irq_req;
        fire     = !mask_q && req_any && !set_mask && !reload;
        mask_nxt = mask_q;
        if (reload)        mask_nxt = reload_mask;
        else if (set_mask) mask_nxt = 1'b1;
        else if (clr_mask) mask_nxt = 1'b0;
        if (fire)          mask_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b1;
            pend_q <= 1'b0;
            take_q <= 1'b0;
        end else begin
            mask_q <= mask_nxt;
            pend_q <= fire ? 1'b0 : req_any;
            take_q <= fire;
        end
    end

    // R5
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mask_q && !pend_q && !take_q));

    // R8
    take_single_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |=> !take_q);

    // R8
    take_masks_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (mask_q && !pend_q));

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && mask_q && !reload && !clr_mask) |=> pend_q);

    // R11
    no_take_on_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mask || reload) |=> !take_q);

    // R10
    pend_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !mask_q && !set_mask && !reload) |=> take_q);
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_class,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_half,
    input  logic              alu_carry,
    input  logic              upd_nz,
    input  logic              upd_c,
    input  logic              cli_stb,
    input  logic              sei_stb,
    input  logic              stop_stb,
    input  logic              wait_stb,
    input  logic              rti_stb,
    input  logic [CCR_W-1:0]  rti_byte,
    input  logic              irq_req,
    output logic [CCR_W-1:0]  ccr_q,
    output logic              take_irq,
    output logic              irq_pending
);
    arith_flags_t flags_q;
    arith_flags_t flags_nxt;
    logic         mask_q;
    logic         clr_any;
    logic         unused_top_bits;

    assign clr_any         = cli_stb | stop_stb | wait_stb;
    assign unused_top_bits = ^rti_byte[CCR_W-1:BIT_H+1];

    ccr_flag_logic #(.DATA_W(DATA_W)) u_flags (
        .cur        (flags_q),
        .oc         (op_class_e'(op_class)),
        .res        (alu_res),
        .half       (alu_half),
        .carry      (alu_carry),
        .upd_nz     (upd_nz),
        .upd_c      (upd_c),
        .reload     (rti_stb),
        .reload_val (unpack_flags(rti_byte)),
        .nxt        (flags_nxt)
    );

    // Flags are deliberately not reset.
    always_ff @(posedge clk) begin
        if (!rst) flags_q <= flags_nxt;
    end

    ccr_mask_ctrl u_mask (
        .clk         (clk),
        .rst         (rst),
        .set_mask    (sei_stb),
        .clr_mask    (clr_any),
        .reload      (rti_stb),
        .reload_mask (rti_byte[BIT_I]),
        .irq_req     (irq_req),
        .mask_q      (mask_q),
        .pend_q      (irq_pending),
        .take_q      (take_irq)
    );

    assign ccr_q = pack_status(flags_q, mask_q);

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        rti_stb |=> (ccr_q[BIT_H:0] == $past(rti_byte[BIT_H:0])));

    // R2
    half_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rti_stb && !is_add_class(op_class_e'(op_class))) |=> $stable(ccr_q[BIT_H]));

    // R4
    carry_load_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_c && !rti_stb) |=> (ccr_q[BIT_C] == $past(alu_carry)));

    // R3
    zero_load_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_nz && !rti_stb) |=> (ccr_q[BIT_Z] == ($past(alu_res) == '0)));
endmodule

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] op_class;
    logic [7:0] alu_res;
    logic       alu_half, alu_carry, upd_nz, upd_c;
    logic       cli_stb, sei_stb, stop_stb, wait_stb, rti_stb;
    logic [7:0] rti_byte;
    logic       irq_req;
    logic [7:0] ccr_q;
    logic       take_irq, irq_pending;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 0;

    // model state
    logic m_h, m_i, m_n, m_z, m_c, m_pend, m_take;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccr_unit dut_i (
        .clk(clk), .rst(rst), .op_class(op_class), .alu_res(alu_res),
        .alu_half(alu_half), .alu_carry(alu_carry), .upd_nz(upd_nz), .upd_c(upd_c),
        .cli_stb(cli_stb), .sei_stb(sei_stb), .stop_stb(stop_stb), .wait_stb(wait_stb),
        .rti_stb(rti_stb), .rti_byte(rti_byte), .irq_req(irq_req),
        .ccr_q(ccr_q), .take_irq(take_irq), .irq_pending(irq_pending)
    );

    function automatic logic [7:0] model_byte();
        return {3'b111, m_h, m_i, m_n, m_z, m_c};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst = 0; op_class = 2'd0; alu_res = 8'h00; alu_half = 0; alu_carry = 0;
        upd_nz = 0; upd_c = 0; cli_stb = 0; sei_stb = 0; stop_stb = 0;
        wait_stb = 0; rti_stb = 0; rti_byte = 8'h00; irq_req = 0;
    endtask

    task automatic model_step();
        logic fire;
        if (rst) begin
            m_i = 1; m_pend = 0; m_take = 0;
        end else begin
            fire = !m_i && (m_pend || irq_req) && !sei_stb && !rti_stb;
            if (rti_stb) begin
                {m_h, m_i, m_n, m_z, m_c} = rti_byte[4:0];
            end else begin
                if (op_class == 2'd1 || op_class == 2'd2) m_h = alu_half;
                if (upd_nz) begin m_n = alu_res[7]; m_z = (alu_res == 8'h00); end
                if (upd_c) m_c = alu_carry;
                if (sei_stb) m_i = 1;
                else if (cli_stb || stop_stb || wait_stb) m_i = 0;
            end
            if (fire) m_i = 1;
            m_pend = fire ? 1'b0 : (m_pend || irq_req);
            m_take = fire;
        end
    endtask

    // One clock: inputs already set; sample 1 time unit after the edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        check("R1", {5'd0, ccr_q[7:5]}, 8'h07);
        check("R2", {7'd0, ccr_q[4]}, {7'd0, m_h});
        check("R6", {7'd0, ccr_q[3]}, {7'd0, m_i});
        check("R3", {6'd0, ccr_q[2:1]}, {6'd0, m_n, m_z});
        check("R4", {7'd0, ccr_q[0]}, {7'd0, m_c});
        check("R8", {7'd0, take_irq}, {7'd0, m_take});
        check("R9", {7'd0, irq_pending}, {7'd0, m_pend});
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] saved;
        void'($urandom(32'd4321));
        m_h = 1'bx; m_n = 1'bx; m_z = 1'bx; m_c = 1'bx;
        m_i = 1; m_pend = 0; m_take = 0;
        idle_inputs();
        rst = 1;
        @(negedge clk);
        rst = 1; cyc();
        rst = 1; cyc();
        // R5: reset state of mask, pulse, pending
        check("R5", {ccr_q[7:5], ccr_q[3], take_irq, irq_pending, 2'b00}, 8'b1111_0000);

        // R7 / R1: reload with top bits zero, mask set
        rti_stb = 1; rti_byte = 8'h08; cyc();
        check("R7", ccr_q, 8'hE8);
        rti_stb = 1; rti_byte = 8'h1F; cyc();
        check("R1", ccr_q, 8'hFF);

        // R5: reset keeps H N Z C
        rti_stb = 1; rti_byte = 8'h15; cyc();
        rst = 1; irq_req = 1; cyc();
        check("R5", ccr_q, 8'hFD);

        // R2: other class ignores half, add loads it
        op_class = 2'd0; alu_half = 0; cyc();
        check("R2", {7'd0, ccr_q[4]}, 8'h01);
        op_class = 2'd3; alu_half = 0; cyc();
        check("R2", {7'd0, ccr_q[4]}, 8'h01);
        op_class = 2'd2; alu_half = 0; cyc();
        check("R2", {7'd0, ccr_q[4]}, 8'h00);

        // R3: zero result and negative result
        upd_nz = 1; alu_res = 8'h00; cyc();
        check("R3", {6'd0, ccr_q[2:1]}, 8'h01);
        upd_nz = 1; alu_res = 8'h80; cyc();
        check("R3", {6'd0, ccr_q[2:1]}, 8'h02);

        // R9 / R10: request while masked, cleared by each way
        irq_req = 1; cyc();
        check("R9", {7'd0, irq_pending}, 8'h01);
        irq_req = 1; cyc();
        cyc();
        cli_stb = 1; cyc();
        check("R10", {ccr_q[3], take_irq, irq_pending, 5'd0}, 8'b0010_0000);
        cyc();
        check("R10", {ccr_q[3], take_irq, irq_pending, 5'd0}, 8'b1100_0000);
        cyc();
        check("R10", {7'd0, take_irq}, 8'h00);

        irq_req = 1; cyc();
        stop_stb = 1; cyc();
        cyc();
        check("R10", {7'd0, take_irq}, 8'h01);
        irq_req = 1; cyc();
        wait_stb = 1; cyc();
        cyc();
        check("R10", {7'd0, take_irq}, 8'h01);
        irq_req = 1; cyc();
        rti_stb = 1; rti_byte = 8'h00; cyc();
        check("R10", {ccr_q[3], take_irq, irq_pending, 5'd0}, 8'b0010_0000);
        cyc();
        check("R10", {7'd0, take_irq}, 8'h01);

        // R11: request with mask clear but set-mask in same cycle
        cli_stb = 1; cyc();
        irq_req = 1; sei_stb = 1; cyc();
        check("R11", {ccr_q[3], take_irq, irq_pending, 5'd0}, 8'b1010_0000);
        cli_stb = 1; sei_stb = 1; cyc();
        check("R6", {7'd0, ccr_q[3]}, 8'h01);
        cli_stb = 1; cyc();
        cyc();
        check("R8", {7'd0, take_irq}, 8'h01);
        cli_stb = 1; cyc();
        irq_req = 1; rti_stb = 1; rti_byte = 8'h00; cyc();
        check("R11", {7'd0, take_irq}, 8'h00);
        cyc();
        check("R11", {7'd0, take_irq}, 8'h01);

        // R8: direct request with mask clear
        cli_stb = 1; cyc();
        irq_req = 1; cyc();
        check("R8", {ccr_q[3], take_irq, irq_pending, 5'd0}, 8'b1100_0000);

        // R4: carry load and hold
        upd_c = 1; alu_carry = 1; cyc();
        check("R4", {7'd0, ccr_q[0]}, 8'h01);
        alu_carry = 0; cyc();
        check("R4", {7'd0, ccr_q[0]}, 8'h01);

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            int sel;
            op_class  = 2'($urandom_range(0, 3));
            alu_res   = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom);
            alu_half  = 1'($urandom);
            alu_carry = 1'($urandom);
            upd_nz    = 1'($urandom);
            upd_c     = 1'($urandom);
            irq_req   = ($urandom_range(0, 5) == 0);
            sel = $urandom_range(0, 19);
            case (sel)
                0: cli_stb = 1;
                1: sei_stb = 1;
                2: stop_stb = 1;
                3: wait_stb = 1;
                4: begin rti_stb = 1; rti_byte = 8'($urandom); end
                5: begin cli_stb = 1; sei_stb = 1; end
                6: rst = ($urandom_range(0, 9) == 0);
                default: ;
            endcase
            cyc();
        end

        saved = model_byte();
        check("R1", {5'd0, ccr_q[7:5]}, {5'd0, saved[7:5]});
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule